// File: doc/BRIEF.md
# Predicate-Count Vector Decrement Unit

This unit carries out one vector instruction: it counts how many lanes of a predicate register are active at the chosen element width, and it then subtracts that count from every lane of a vector register. The vector register is both the source and the destination. The instruction word is decoded inside the unit. The decoder checks the fixed opcode bits and pulls out the element-size code, the predicate register index and the vector register index. Words that cannot be executed raise an undefined flag, and no result is produced for them. A word cannot be executed if the opcode bits do not match, if the size code is reserved, or if the enable input is low.

The vector length is a parameter. It must be a multiple of 128 bits, and the default is 256. The predicate register holds one bit per vector byte, so it is one eighth of the vector length. There is one register stage. Operands and the instruction word presented with `valid_i` at one rising edge appear on the outputs after that edge. The register file supplies the operands and takes the result. It writes `res_o` back to register `zdn_idx_o` when `valid_o` is high.

Top module: `pcnt_vdec`

## Requirements
- R1: The decoder reads the size code from insn_i[23:22], the predicate index from insn_i[8:5] and the vector index from insn_i[4:0]. The size codes select the element width: 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes.
- R2: A word with size code 2'b00 makes undef_o high and valid_o low. In that case res_o and the index outputs keep their previous values.
- R3: A word is undefined unless insn_i[31:24] equals 8'h25 and insn_i[21:9] equals 13'b1011011000000.
- R4: When en_i is low, an accepted word gives undef_o high and valid_o low, and res_o keeps its previous value.
- R5: The subtrahend is the number of lanes e, for e from 0 to VL/esize-1, whose predicate bit at index e*(esize/8) is 1. All other predicate bits have no effect on the result.
- R6: Every lane of res_o equals the matching lane of vec_i minus the subtrahend. This holds whatever the lane's own predicate bit is.
- R7: Each lane subtraction wraps modulo 2^esize. No saturation is applied and no flags are produced.
- R8: The outputs are registered. After a rising edge with valid_i high, valid_o equals "word executable" and undef_o equals "word not executable". With valid_i low, both are low. The two are never high together.
- R9: While rst_ni is low, valid_o, undef_o, res_o and the index outputs are all zero.
- R10: size_o, pm_idx_o and zdn_idx_o present the decoded fields of the word, in the same cycle as its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable; a low level makes every accepted word undefined |
| valid_i | input | 1 | Instruction word and operands are present |
| insn_i | input | 32 | Instruction word |
| vec_i | input | VL_BITS | Vector source operand |
| pred_i | input | VL_BITS/8 | Predicate source operand, one bit per byte |
| valid_o | output | 1 | The result is valid and may be written back |
| undef_o | output | 1 | The accepted word was undefined |
| res_o | output | VL_BITS | Result vector |
| size_o | output | 2 | Decoded element-size code |
| pm_idx_o | output | 4 | Decoded predicate register index |
| zdn_idx_o | output | 5 | Decoded source and destination vector index |

## Verification
The hardest case to reach from the ports is a predicate whose active bits all sit at positions the selected element size ignores. It has to give a count of zero, and the vector must pass through unchanged. The bench builds this case directly. It sets every predicate bit and then clears each bit that is sampled at the current width, which leaves only ignored bits set. A second case needs the subtrahend to exceed the lane values, so that every lane wraps. The bench gets there with an all-zero vector under an all-ones predicate.

// File: rtl/pcnt_vdec_pkg.sv
package pcnt_vdec_pkg;
  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_H    = 2'b01,
    SZ_S    = 2'b10,
    SZ_D    = 2'b11
  } esz_e;

  localparam logic [7:0]  OPC_HI  = 8'h25;
  localparam logic [12:0] OPC_MID = 13'b1011011000000;

  typedef struct packed {
    esz_e       size;
    logic [3:0] pm;
    logic [4:0] zdn;
  } dec_fields_t;
endpackage

// File: rtl/pcnt_vdec_decode.sv
module pcnt_vdec_decode
  import pcnt_vdec_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        en_i,
  output dec_fields_t fields_o,
  output logic        undef_o
);
  logic opc_ok;

  assign fields_o.size = esz_e'(insn_i[23:22]);
  assign fields_o.pm   = insn_i[8:5];
  assign fields_o.zdn  = insn_i[4:0];

  assign opc_ok  = (insn_i[31:24] == OPC_HI) && (insn_i[21:9] == OPC_MID);
  assign undef_o = !en_i || !opc_ok || (fields_o.size == SZ_RSVD);
endmodule

// File: rtl/pcnt_vdec_count.sv
module pcnt_vdec_count
  import pcnt_vdec_pkg::*;
#(
  parameter int unsigned VL_BITS = 256,
  localparam int unsigned PL_BITS = VL_BITS / 8,
  localparam int unsigned CNT_W   = $clog2(VL_BITS / 16 + 1)
) (
  input  logic [PL_BITS-1:0] pred_i,
  input  esz_e               size_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [CNT_W-1:0] cnt_sz [4];

  assign cnt_sz[0] = '0;

  for (genvar s = 1; s < 4; s++) begin : g_sz
    localparam int unsigned LANES = VL_BITS / (8 << s);
    localparam int unsigned STEP  = 1 << s;  // predicate bits per lane
    always_comb begin
      cnt_sz[s] = '0;
      for (int e = 0; e < LANES; e++)
        cnt_sz[s] = cnt_sz[s] + CNT_W'(pred_i[e*STEP]);
    end
  end

  assign cnt_o = cnt_sz[size_i];

  always_comb begin
    if (pred_i == '0) AST_CNT_ZERO: assert (cnt_o == '0); // R5
  end
endmodule

// File: rtl/pcnt_vdec_lanes.sv
module pcnt_vdec_lanes #(
  parameter int unsigned VL_BITS = 256,
  parameter int unsigned EW      = 16,
  parameter int unsigned CNT_W   = 5,
  localparam int unsigned LANES  = VL_BITS / EW
) (
  input  logic [VL_BITS-1:0] vec_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [VL_BITS-1:0] res_o
);
  logic [EW-1:0] sub;
  assign sub = EW'(cnt_i);

  // every lane, active or not; wraps mod 2^EW
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    assign res_o[e*EW +: EW] = vec_i[e*EW +: EW] - sub;
  end
endmodule

// File: rtl/pcnt_vdec.sv
module pcnt_vdec
  import pcnt_vdec_pkg::*;
#(
  parameter int unsigned VL_BITS = 256,
  localparam int unsigned PL_BITS = VL_BITS / 8,
  localparam int unsigned CNT_W   = $clog2(VL_BITS / 16 + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               valid_i,
  input  logic [31:0]        insn_i,
  input  logic [VL_BITS-1:0] vec_i,
  input  logic [PL_BITS-1:0] pred_i,
  output logic               valid_o,
  output logic               undef_o,
  output logic [VL_BITS-1:0] res_o,
  output logic [1:0]         size_o,
  output logic [3:0]         pm_idx_o,
  output logic [4:0]         zdn_idx_o
);
  dec_fields_t         dec;
  logic                dec_undef;
  logic [CNT_W-1:0]    cnt;
  logic [VL_BITS-1:0]  res_sz [4];
  logic [VL_BITS-1:0]  res_n;
  logic                fire;

  pcnt_vdec_decode u_dec (
    .insn_i   (insn_i),
    .en_i     (en_i),
    .fields_o (dec),
    .undef_o  (dec_undef)
  );

  pcnt_vdec_count #(.VL_BITS(VL_BITS)) u_cnt (
    .pred_i (pred_i),
    .size_i (dec.size),
    .cnt_o  (cnt)
  );

  assign res_sz[0] = '0;
  for (genvar s = 1; s < 4; s++) begin : g_sub
    pcnt_vdec_lanes #(
      .VL_BITS (VL_BITS),
      .EW      (8 << s),
      .CNT_W   (CNT_W)
    ) u_lanes (
      .vec_i (vec_i),
      .cnt_i (cnt),
      .res_o (res_sz[s])
    );
  end

  assign res_n = res_sz[dec.size];
  assign fire  = valid_i && !dec_undef;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      undef_o   <= 1'b0;
      res_o     <= '0;
      size_o    <= '0;
      pm_idx_o  <= '0;
      zdn_idx_o <= '0;
    end else begin
      valid_o <= fire;
      undef_o <= valid_i && dec_undef;
      if (fire) begin
        res_o     <= res_n;
        size_o    <= dec.size;
        pm_idx_o  <= dec.pm;
        zdn_idx_o <= dec.zdn;
      end
    end
  end

  AST_RSVD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[23:22] == 2'b00 |=> undef_o && !valid_o); // R2
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(res_o)); // R2
  AST_BAD_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:24] != 8'h25 |=> undef_o); // R3
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !en_i |=> undef_o && !valid_o); // R4
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && undef_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !undef_o); // R8
endmodule

// File: tb/pcnt_vdec_tb_top.sv
module pcnt_vdec_tb_top;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          valid_i = 1'b0;
  logic [31:0]   insn_i = '0;
  logic [VL-1:0] vec_i = '0;
  logic [PL-1:0] pred_i = '0;
  logic          valid_o, undef_o;
  logic [VL-1:0] res_o;
  logic [1:0]    size_o;
  logic [3:0]    pm_idx_o;
  logic [4:0]    zdn_idx_o;

  int total = 0;
  int bad = 0;

  pcnt_vdec #(.VL_BITS(VL)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] mk_insn(logic [1:0] sz, logic [3:0] pm, logic [4:0] zdn);
    return {8'h25, sz, 13'b1011011000000, pm, zdn};
  endfunction

  function automatic logic [VL-1:0] rand_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VL-1:0] ref_res(logic [VL-1:0] v, logic [PL-1:0] p, int sz);
    int ew = 8 << sz;
    int lanes = VL / ew;
    int cnt = 0;
    logic [VL-1:0] mask = (VL'(1) << ew) - VL'(1);
    logic [VL-1:0] r = '0;
    for (int e = 0; e < lanes; e++) if (p[e * (ew / 8)]) cnt++;
    for (int e = 0; e < lanes; e++) begin
      logic [VL-1:0] lane = (v >> (e * ew)) & mask;
      r |= ((lane - VL'(cnt)) & mask) << (e * ew);
    end
    return r;
  endfunction

  function automatic logic [PL-1:0] ignored_only(int sz);
    logic [PL-1:0] p = '1;
    int step = 1 << sz;
    for (int e = 0; e < PL / step; e++) p[e*step] = 1'b0;
    return p;
  endfunction

  task automatic chk(string req, logic [VL-1:0] act, logic [VL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic en, logic vld, logic [31:0] w, logic [VL-1:0] v, logic [PL-1:0] p);
    @(negedge clk_i);
    en_i = en; valid_i = vld; insn_i = w; vec_i = v; pred_i = p;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run_ok(string req, int sz, logic [VL-1:0] v, logic [PL-1:0] p);
    logic [3:0] pm = 4'($urandom);
    logic [4:0] zd = 5'($urandom);
    issue(1'b1, 1'b1, mk_insn(2'(sz), pm, zd), v, p);
    chk({req, "/R6 res"}, res_o, ref_res(v, p, sz));
    chk({req, "/R8 valid"}, VL'({valid_o, undef_o}), VL'(2'b10));
    chk("R1/R10 fields", VL'({size_o, pm_idx_o, zdn_idx_o}), VL'({2'(sz), pm, zd}));
  endtask

  task automatic run_bad(string req, logic en, logic [31:0] w);
    logic [VL-1:0] prev = res_o;
    issue(en, 1'b1, w, rand_vec(), '1);
    chk({req, " flags"}, VL'({valid_o, undef_o}), VL'(2'b01));
    chk({req, " hold"}, res_o, prev);
  endtask

  initial begin
    #1;
    chk("R9 reset", VL'({valid_o, undef_o, size_o, pm_idx_o, zdn_idx_o}), '0);
    chk("R9 reset res", res_o, '0);
    #50 rst_ni = 1'b1;

    for (int sz = 1; sz < 4; sz++) begin
      run_ok("R5 zero-pred", sz, rand_vec(), '0);
      run_ok("R5 ones-pred", sz, rand_vec(), '1);
      run_ok("R5 ignored-bits", sz, rand_vec(), ignored_only(sz));
      chk("R5 ignored passthru", res_o, vec_i);
      run_ok("R7 wrap", sz, '0, '1);
      for (int k = 0; k < 20; k++) run_ok("R5 random", sz, rand_vec(), PL'($urandom));
    end

    run_bad("R2 rsvd size", 1'b1, mk_insn(2'b00, 4'd3, 5'd7));
    run_bad("R3 bad hi", 1'b1, mk_insn(2'b01, 4'd1, 5'd2) ^ 32'h0100_0000);
    run_bad("R3 bad mid", 1'b1, mk_insn(2'b10, 4'd1, 5'd2) ^ 32'h0000_0200);
    run_bad("R4 en low", 1'b0, mk_insn(2'b11, 4'd1, 5'd2));

    issue(1'b1, 1'b0, mk_insn(2'b01, 4'd0, 5'd0), rand_vec(), '1);
    chk("R8 idle", VL'({valid_o, undef_o}), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule